// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level translation tree in memory. A request carries the virtual address, a write flag and a user-mode flag. Together with the root pointer of the current directory it starts a walk. The walker first reads a first-level (directory) entry. If that entry maps a 4 MiB page, the walk stops there. Otherwise the walker reads a second-level (table) entry that maps a 4 KiB page. Presence and access rights are checked at every level.

The walker keeps the usage flags in memory current. When an entry is used for a successful step and its accessed flag is clear, it writes the entry back with that flag set. On a write access it also sets the modified flag in the entry that maps the final page. Each write-back is a read-modify-write on a single memory port with a valid/ready handshake, and only one access is in flight at a time.

The result is a one-cycle response. It carries either the physical address together with the pass-through attribute bits, or a fault code that gives the cause and the level at which the walk stopped.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `mem_valid` and `resp_valid` are 0.
- R2: The first memory access of a walk is a read at `{dir_base[31:12], va[31:22], 2'b00}`. Bits 11:0 of `dir_base` are ignored. For a 4 KiB mapping, the table entry is then read at `{pde[31:12], va[21:12], 2'b00}`.
- R3: Entry flag positions are: bit0 present, bit1 writable, bit2 user, bit3 write-through, bit4 cache-off, bit5 accessed, bit6 modified, bit7 large page (directory only), bit8 global. A successful 4 KiB walk returns `resp_paddr = {pte[31:12], va[11:0]}` and `resp_attr = {pte[8], pte[4], pte[3]}`.
- R4: A present directory entry with bit7 set ends the walk at the directory level. No table read is made. The walk returns `{pde[31:22], va[21:0]}`, with the attributes taken from the directory entry.
- R5: An entry with bit0 clear stops the walk with a not-present fault. That entry is not written, and its other bits have no effect on the result.
- R6: At each level, a write to an entry with bit1 clear, or a user access to an entry with bit2 clear, stops the walk with a protection fault at that level. A walk therefore succeeds only if both levels grant the right.
- R7: Every entry that passes its checks is written back with bit5 set, at the same address, before the walk continues. A write-back happens only when the entry value changes.
- R8: On a write access, bit6 is set in the final entry (the table entry, or a large-page directory entry). A directory entry that points to a table never gets bit6 set.
- R9: While `mem_valid` is high and `mem_ready` is low, the address, write flag and write data are held stable. Read data is taken in the cycle of the handshake.
- R10: `resp_fault` is `{cause[1:0], level}`. The cause is 00 for success, 01 for not present and 10 for protection. The level is 0 for the directory and 1 for the table. On a fault, `resp_paddr` and `resp_attr` are 0.
- R11: A request is accepted only while `req_ready` is high. Its inputs are captured at acceptance, and later changes have no effect on that walk. `req_ready` stays low until after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| dir_base | input | 32 | Physical address of the directory (bits 31:12 used) |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_fault | output | 3 | {cause, level}, 000 on success |
| resp_paddr | output | 32 | Translated physical address |
| resp_attr | output | 3 | {global, cache-off, write-through} of the final entry |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts / returns data this cycle |
| mem_write | output | 1 | Access is a write-back |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 32 | Updated entry value |
| mem_rdata | input | 32 | Entry value, valid with the handshake |

## Verification
The hardest case to reach is a walk whose levels disagree on rights or on flag state. Examples are a directory that grants user access over a table that denies it, a directory entry that is already marked accessed over a table entry that is not, and a not-present table entry whose other bits are all set. The bench builds directories and tables in its own memory so that one virtual address reaches each such pairing. It repeats accesses so that the second walk finds the flags the first one wrote. The memory's ready is stretched on some walks to hold requests pending, and the request inputs are scrambled just after acceptance.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ADDR_W   = 32;
  localparam int OFF_W    = 12;
  localparam int IDX_W    = 10;
  localparam int BIG_OFF_W = OFF_W + IDX_W;
  localparam int FRAME_W  = ADDR_W - OFF_W;
  localparam int BIG_FRAME_W = ADDR_W - BIG_OFF_W;

  localparam int FB_PRESENT = 0;
  localparam int FB_WRITE   = 1;
  localparam int FB_USER    = 2;
  localparam int FB_WTHRU   = 3;
  localparam int FB_NOCACHE = 4;
  localparam int FB_USED    = 5;
  localparam int FB_MOD     = 6;
  localparam int FB_BIG     = 7;
  localparam int FB_GLOBAL  = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_DIR_RD, S_DIR_EV, S_DIR_WB, S_TBL_RD, S_TBL_EV, S_TBL_WB, S_DONE
  } walk_state_t;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_ABSENT = 2'b01,
    CAUSE_PROT   = 2'b10
  } cause_t;
endpackage

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
  import ptw_pkg::*;
(
  input  logic [ADDR_W-1:0] entry,
  input  logic              acc_write,
  input  logic              acc_user,
  input  logic              is_leaf,
  output logic              absent,
  output logic              denied,
  output logic [ADDR_W-1:0] entry_upd,
  output logic              upd_needed
);
  logic [ADDR_W-1:0] set_mask;

  always_comb begin
    absent = !entry[FB_PRESENT];
    denied = entry[FB_PRESENT] &&
             ((acc_write && !entry[FB_WRITE]) || (acc_user && !entry[FB_USER]));
    set_mask = '0;
    set_mask[FB_USED] = 1'b1;
    set_mask[FB_MOD]  = is_leaf && acc_write;
    entry_upd  = entry | set_mask;
    upd_needed = (entry_upd != entry);
  end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic [FRAME_W-1:0] base_frame,
  input  logic [ADDR_W-1:0]  va,
  input  logic [FRAME_W-1:0] pde_frame,
  input  logic [FRAME_W-1:0] pte_frame,
  output logic [ADDR_W-1:0]  dir_addr,
  output logic [ADDR_W-1:0]  tbl_addr,
  output logic [ADDR_W-1:0]  pa_small,
  output logic [ADDR_W-1:0]  pa_big
);
  always_comb begin
    dir_addr = {base_frame, va[ADDR_W-1 -: IDX_W], 2'b00};
    tbl_addr = {pde_frame, va[BIG_OFF_W-1 -: IDX_W], 2'b00};
    pa_small = {pte_frame, va[OFF_W-1:0]};
    pa_big   = {pde_frame[FRAME_W-1 -: BIG_FRAME_W], va[BIG_OFF_W-1:0]};
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  input  logic        req_user,
  input  logic [31:0] dir_base,
  output logic        resp_valid,
  output logic [2:0]  resp_fault,
  output logic [31:0] resp_paddr,
  output logic [2:0]  resp_attr,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic        mem_write,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata
);
  walk_state_t state_q, state_d;

  logic [ADDR_W-1:0]  va_q;
  logic               wr_q, usr_q;
  logic [FRAME_W-1:0] base_q;
  logic [ADDR_W-1:0]  pde_q, pte_q;
  logic               cap_req, cap_pde, cap_pte;

  logic [2:0]         fault_q, fault_d;
  logic [ADDR_W-1:0]  pa_q, pa_d;
  logic [2:0]         attr_q, attr_d;
  logic               fin_load;

  logic               in_tbl;
  logic [ADDR_W-1:0]  cur_entry;
  logic               cur_leaf, cur_absent, cur_denied, cur_upd_needed;
  logic [ADDR_W-1:0]  cur_upd;
  logic [ADDR_W-1:0]  dir_addr, tbl_addr, pa_small, pa_big;
  logic               big_page;

  assign in_tbl    = (state_q == S_TBL_EV) || (state_q == S_TBL_WB);
  assign cur_entry = in_tbl ? pte_q : pde_q;
  assign big_page  = pde_q[FB_BIG];
  assign cur_leaf  = in_tbl || big_page;

  ptw_entry_eval u_eval (
    .entry      (cur_entry),
    .acc_write  (wr_q),
    .acc_user   (usr_q),
    .is_leaf    (cur_leaf),
    .absent     (cur_absent),
    .denied     (cur_denied),
    .entry_upd  (cur_upd),
    .upd_needed (cur_upd_needed)
  );

  ptw_addr_gen u_addr (
    .base_frame (base_q),
    .va         (va_q),
    .pde_frame  (pde_q[ADDR_W-1:OFF_W]),
    .pte_frame  (pte_q[ADDR_W-1:OFF_W]),
    .dir_addr   (dir_addr),
    .tbl_addr   (tbl_addr),
    .pa_small   (pa_small),
    .pa_big     (pa_big)
  );

  // next-state and result computation
  always_comb begin
    state_d  = state_q;
    cap_req  = 1'b0;
    cap_pde  = 1'b0;
    cap_pte  = 1'b0;
    fin_load = 1'b0;
    fault_d  = 3'b000;
    pa_d     = '0;
    attr_d   = 3'b000;
    case (state_q)
      S_IDLE: if (req_valid) begin
        cap_req = 1'b1;
        state_d = S_DIR_RD;
      end
      S_DIR_RD: if (mem_ready) begin
        cap_pde = 1'b1;
        state_d = S_DIR_EV;
      end
      S_DIR_EV: begin
        if (cur_absent) begin
          fin_load = 1'b1;
          fault_d  = {CAUSE_ABSENT, 1'b0};
          state_d  = S_DONE;
        end else if (cur_denied) begin
          fin_load = 1'b1;
          fault_d  = {CAUSE_PROT, 1'b0};
          state_d  = S_DONE;
        end else if (cur_upd_needed) begin
          state_d = S_DIR_WB;
        end else if (big_page) begin
          fin_load = 1'b1;
          pa_d     = pa_big;
          attr_d   = {pde_q[FB_GLOBAL], pde_q[FB_NOCACHE], pde_q[FB_WTHRU]};
          state_d  = S_DONE;
        end else begin
          state_d = S_TBL_RD;
        end
      end
      S_DIR_WB: if (mem_ready) begin
        if (big_page) begin
          fin_load = 1'b1;
          pa_d     = pa_big;
          attr_d   = {pde_q[FB_GLOBAL], pde_q[FB_NOCACHE], pde_q[FB_WTHRU]};
          state_d  = S_DONE;
        end else begin
          state_d = S_TBL_RD;
        end
      end
      S_TBL_RD: if (mem_ready) begin
        cap_pte = 1'b1;
        state_d = S_TBL_EV;
      end
      S_TBL_EV: begin
        if (cur_absent) begin
          fin_load = 1'b1;
          fault_d  = {CAUSE_ABSENT, 1'b1};
          state_d  = S_DONE;
        end else if (cur_denied) begin
          fin_load = 1'b1;
          fault_d  = {CAUSE_PROT, 1'b1};
          state_d  = S_DONE;
        end else if (cur_upd_needed) begin
          state_d = S_TBL_WB;
        end else begin
          fin_load = 1'b1;
          pa_d     = pa_small;
          attr_d   = {pte_q[FB_GLOBAL], pte_q[FB_NOCACHE], pte_q[FB_WTHRU]};
          state_d  = S_DONE;
        end
      end
      S_TBL_WB: if (mem_ready) begin
        fin_load = 1'b1;
        pa_d     = pa_small;
        attr_d   = {pte_q[FB_GLOBAL], pte_q[FB_NOCACHE], pte_q[FB_WTHRU]};
        state_d  = S_DONE;
      end
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q   <= '0;
      wr_q   <= 1'b0;
      usr_q  <= 1'b0;
      base_q <= '0;
    end else if (cap_req) begin
      va_q   <= req_vaddr;
      wr_q   <= req_write;
      usr_q  <= req_user;
      base_q <= dir_base[ADDR_W-1:OFF_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pde_q <= '0;
    else if (cap_pde) pde_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pte_q <= '0;
    else if (cap_pte) pte_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 3'b000;
      pa_q    <= '0;
      attr_q  <= 3'b000;
    end else if (fin_load) begin
      fault_q <= fault_d;
      pa_q    <= pa_d;
      attr_q  <= attr_d;
    end
  end

  assign req_ready  = (state_q == S_IDLE);
  assign resp_valid = (state_q == S_DONE);
  assign resp_fault = fault_q;
  assign resp_paddr = pa_q;
  assign resp_attr  = attr_q;

  assign mem_valid = (state_q == S_DIR_RD) || (state_q == S_DIR_WB) ||
                     (state_q == S_TBL_RD) || (state_q == S_TBL_WB);
  assign mem_write = (state_q == S_DIR_WB) || (state_q == S_TBL_WB);
  assign mem_addr  = ((state_q == S_DIR_RD) || (state_q == S_DIR_WB)) ? dir_addr : tbl_addr;
  assign mem_wdata = mem_write ? cur_upd : '0;

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_write) && $stable(mem_wdata)));

  assert_wb_marks_used_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write) |-> mem_wdata[FB_USED]);

  assert_fault_clears_pa_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault != 3'b000) |-> (resp_paddr == '0 && resp_attr == 3'b000));

  assert_cause_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_fault[2:1] != 2'b11));

  assert_busy_no_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid || resp_valid) |-> !req_ready);

  assert_one_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  assert_absent_no_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault[2:1] == 2'b01) |-> $past(!mem_write));
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic [31:0] dir_base = '0;
  logic        resp_valid;
  logic [2:0]  resp_fault;
  logic [31:0] resp_paddr;
  logic [2:0]  resp_attr;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic        mem_write;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;

  int errors = 0;
  int checks = 0;
  int resp_count = 0;
  int cycle = 0;
  int slow_mem = 0;
  string cur_tag = "";

  logic [31:0] mem [0:4095];
  logic [64:0] exp_acc [$];
  logic [2:0]  exp_fault;
  logic [31:0] exp_pa;
  logic [2:0]  exp_attr;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
    .dir_base(dir_base), .resp_valid(resp_valid), .resp_fault(resp_fault),
    .resp_paddr(resp_paddr), .resp_attr(resp_attr), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr[13:2]];

  always @(posedge clk) begin
    cycle <= cycle + 1;
    if (mem_valid && mem_ready && mem_write) mem[mem_addr[13:2]] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_tag, what, act, expv);
    end
  endtask

  // memory ready pattern and per-clock comparison against the model
  always @(negedge clk) begin
    mem_ready = (slow_mem == 0) ? 1'b1 : ((cycle % 3) == 2);
    if (rst_n && mem_valid && mem_ready) begin
      if (exp_acc.size() == 0) begin
        chk(1'b0, "R7 unexpected memory access", mem_addr, 32'h0);
      end else begin
        logic [64:0] e;
        e = exp_acc.pop_front();
        chk(mem_write == e[64], "R7 access kind", {31'b0, mem_write}, {31'b0, e[64]});
        chk(mem_addr == e[63:32], "R2 access address", mem_addr, e[63:32]);
        if (e[64]) chk(mem_wdata == e[31:0], "R8 write-back value", mem_wdata, e[31:0]);
      end
    end
    if (rst_n && resp_valid) begin
      chk(resp_fault == exp_fault, "R10 fault code", {29'b0, resp_fault}, {29'b0, exp_fault});
      chk(resp_paddr == exp_pa, "R3 physical address", resp_paddr, exp_pa);
      chk(resp_attr == exp_attr, "R3 attributes", {29'b0, resp_attr}, {29'b0, exp_attr});
      chk(exp_acc.size() == 0, "R7 missing memory access", exp_acc.size(), 32'h0);
      resp_count++;
    end
  end

  task automatic predict(input logic [31:0] va, input bit wr, input bit usr, input logic [31:0] base);
    logic [31:0] da, ta, pde, pte, upd;
    exp_fault = 3'b000; exp_pa = '0; exp_attr = 3'b000;
    da = {base[31:12], va[31:22], 2'b00};
    exp_acc.push_back({1'b0, da, 32'h0});
    pde = mem[da[13:2]];
    if (!pde[0]) begin exp_fault = 3'b010; return; end
    if ((wr && !pde[1]) || (usr && !pde[2])) begin exp_fault = 3'b100; return; end
    upd = pde | 32'h20 | ((pde[7] && wr) ? 32'h40 : 32'h0);
    if (upd != pde) exp_acc.push_back({1'b1, da, upd});
    if (pde[7]) begin
      exp_pa = {pde[31:22], va[21:0]};
      exp_attr = {pde[8], pde[4], pde[3]};
      return;
    end
    ta = {pde[31:12], va[21:12], 2'b00};
    exp_acc.push_back({1'b0, ta, 32'h0});
    pte = mem[ta[13:2]];
    if (!pte[0]) begin exp_fault = 3'b011; return; end
    if ((wr && !pte[1]) || (usr && !pte[2])) begin exp_fault = 3'b101; return; end
    upd = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
    if (upd != pte) exp_acc.push_back({1'b1, ta, upd});
    exp_pa = {pte[31:12], va[11:0]};
    exp_attr = {pte[8], pte[4], pte[3]};
  endtask

  task automatic walk(input string tag, input logic [31:0] va, input bit wr, input bit usr,
                      input logic [31:0] base);
    int old;
    @(negedge clk);
    cur_tag = tag;
    chk(req_ready == 1'b1, "R11 ready before request", {31'b0, req_ready}, 32'h1);
    predict(va, wr, usr, base);
    old = resp_count;
    req_vaddr = va; req_write = wr; req_user = usr; dir_base = base;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_vaddr = ~va; req_write = ~wr; req_user = ~usr; dir_base = 32'h0000_5000;
    chk(req_ready == 1'b0, "R11 busy after accept", {31'b0, req_ready}, 32'h0);
    while (resp_count == old) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    // directory at 0x1000, tables at 0x2000 and 0x3000
    mem[12'h400 + 0] = 32'h0000_2007;
    mem[12'h800 + 5] = 32'hABCD_E01F;
    mem[12'h400 + 1] = 32'h0000_0000;
    mem[12'h400 + 2] = 32'h0000_3027;
    mem[12'hC00 + 0] = 32'hFFFF_F0FE;
    mem[12'hC00 + 1] = 32'h1234_5023;
    mem[12'hC00 + 2] = 32'h5555_5167;
    mem[12'h400 + 3] = 32'h0000_3025;
    mem[12'h400 + 4] = 32'h8040_0187;
    mem[12'h400 + 5] = 32'h0000_00A3;
    mem[12'h800 + 6] = 32'h0765_4003;

    repeat (3) @(negedge clk);
    cur_tag = "R1";
    chk(req_ready == 1'b1, "R1 ready in reset", {31'b0, req_ready}, 32'h1);
    chk(mem_valid == 1'b0, "R1 no memory access in reset", {31'b0, mem_valid}, 32'h0);
    chk(resp_valid == 1'b0, "R1 no response in reset", {31'b0, resp_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    walk("R2 R3 R7 first use", 32'h0000_5123, 1'b0, 1'b1, 32'h0000_1000);
    walk("R7 flags already set", 32'h0000_5FFF, 1'b0, 1'b1, 32'h0000_1000);
    walk("R8 first write", 32'h0000_5004, 1'b1, 1'b0, 32'h0000_1000);
    walk("R7 R8 repeat write", 32'h0000_5008, 1'b1, 1'b1, 32'h0000_1000);
    slow_mem = 1;
    walk("R5 R9 absent directory", 32'h0040_0000, 1'b0, 1'b0, 32'h0000_1000);
    walk("R5 absent table", 32'h0080_0ABC, 1'b1, 1'b1, 32'h0000_1000);
    walk("R6 directory write denied", 32'h00C0_2000, 1'b1, 1'b0, 32'h0000_1000);
    walk("R6 table user denied", 32'h0080_1010, 1'b0, 1'b1, 32'h0000_1000);
    walk("R6 supervisor ok", 32'h0080_1010, 1'b0, 1'b0, 32'h0000_1000);
    walk("R6 user read both levels", 32'h00C0_2ABC, 1'b0, 1'b1, 32'h0000_1000);
    slow_mem = 0;
    walk("R4 R8 large page write", 32'h0112_3456, 1'b1, 1'b1, 32'h0000_1000);
    walk("R4 large page read", 32'h013F_FFFF, 1'b0, 1'b0, 32'h0000_1000);
    walk("R6 large page user denied", 32'h0140_0000, 1'b0, 1'b1, 32'h0000_1000);
    walk("R2 base low bits ignored", 32'h0000_6FF0, 1'b0, 1'b0, 32'h0000_1ABC);

    @(negedge clk);
    cur_tag = "R7 memory state";
    chk(mem[12'h400] == 32'h0000_2027, "R8 directory keeps modified clear", mem[12'h400], 32'h0000_2027);
    chk(mem[12'h400 + 1] == 32'h0, "R5 absent entry untouched", mem[12'h401], 32'h0);
    chk(mem[12'hC00] == 32'hFFFF_F0FE, "R5 absent table entry untouched", mem[12'hC00], 32'hFFFF_F0FE);
    chk(mem[12'h400 + 4] == 32'h8040_01E7, "R8 large page flags", mem[12'h404], 32'h8040_01E7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule